// File: doc/BRIEF.md
# Programmable Memory Window Decoder

This block sits between a CPU's 16-bit address bus and the physical memories of a 256 KB machine. The 64 KB address space is cut into sixteen 4 KB windows. On every access, reads and writes looked up separately, the block decides whether the window reaches RAM, ROM or the video memory. It also forms the physical page number for RAM and ROM. The choice comes from a byte-wide lookup table, not from fixed comparators, so a read and a write to the same window can land in different places.

The CPU picks the active mapping by writing a six-bit selector through an I/O port. The table is loaded through a separate configuration port before use. The decode path from address, access type and selector to the outputs is purely combinational. Only the selector register and the table storage are clocked.

Top module: `membank_decoder`

## Requirements
- R1: An I/O write to port 0x50 loads bits 5:0 of `io_data` into the selector on the rising clock edge. Data bits 7:6 are dropped. A write to any other port leaves the selector unchanged.
- R2: The selector bits S0..S5 feed the 14-bit table index as follows: S0 to bit 8, S1 to bit 9, S4 to bit 11, S2 to bit 12 and S3 to bit 13. Bit 10 is 0, and S5 takes no part in the index.
- R3: The window number A15..A12 feeds the index as follows: A12 to bit 0, A14 to bit 2, A13 to bit 3 and A15 to bit 4. Bit 5 is 0.
- R4: A read sets index bits 7 and 1 and clears bit 6. A write sets index bits 7 and 6 and clears bit 1.
- R5: The table byte is decoded as follows. The RAM bank bit 0 comes from byte bit 4, bank bit 1 from byte bit 1 and bank bit 2 from byte bit 2. Byte bit 6 low selects ROM. Byte bit 3 low selects video.
- R6: RAM bank bit 2 is forced to 0 while selector bit S5 is 0.
- R7: Video takes priority over ROM and RAM. When video is selected, `vid_sel` is 1 and `vid_upper` equals A11, so the lower and upper 2 KB of the window go to separate video regions.
- R8: A read with ROM selected and video not selected gives `rom_sel`=1 and `rom_page` = A13..A12.
- R9: A write with ROM selected and video not selected gives `wr_discard`=1 and no other target.
- R10: Otherwise `ram_sel`=1 and `ram_page` = {bank, A14..A12}. On every access exactly one of `vid_sel`, `rom_sel`, `ram_sel` and `wr_discard` is 1. Page outputs that do not belong to the chosen target read 0.
- R11: Reset clears the selector to 0. `boot_addr` always reads 0x8000.
- R12: A configuration write stores `cfg_data` at `cfg_index` when that index can be formed by R2 to R4. A write to any other index changes no stored entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe |
| io_port | input | 8 | I/O port number |
| io_data | input | 8 | I/O write data |
| cpu_addr | input | 16 | CPU memory address |
| cpu_wr | input | 1 | 1 = write access, 0 = read access |
| cfg_we | input | 1 | Table load strobe |
| cfg_index | input | 14 | Table index to load |
| cfg_data | input | 8 | Table byte to load |
| vid_sel | output | 1 | Access goes to video memory |
| vid_upper | output | 1 | Upper 2 KB video region selected |
| ram_sel | output | 1 | Access goes to RAM |
| ram_page | output | 6 | Physical 4 KB RAM page |
| rom_sel | output | 1 | Read goes to ROM |
| rom_page | output | 2 | ROM 4 KB page |
| wr_discard | output | 1 | Write is dropped |
| boot_addr | output | 16 | CPU start address after reset |

## Verification
A corrupt selector bit or a wrong table entry shows at the ports in the same cycle, as a different target or page for every window that the bad state touches. A stale selector after a port write appears as early as the first access after the next clock edge. The bench loads every reachable table entry with a computed byte pattern. It then sweeps all 64 selector values over all windows, both access types and both video halves, so a single swapped index or output bit makes many checks fail at once.

// File: rtl/bankdec_pkg.sv
package bankdec_pkg;

    localparam int ADDR_W  = 16;
    localparam int WIN_W   = 4;
    localparam int SEL_W   = 6;
    localparam int IDX_W   = 14;
    localparam int ENT_W   = 8;
    localparam int CIDX_W  = 10;
    localparam int BANK_W  = 3;
    localparam int PAGE_W  = BANK_W + 3;
    localparam int ROMPG_W = 2;

    typedef enum logic [1:0] {
        TGT_RAM   = 2'd0,
        TGT_ROM   = 2'd1,
        TGT_VIDEO = 2'd2,
        TGT_DROP  = 2'd3
    } target_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic              rom_n;
        logic              vid_n;
    } entry_t;

    typedef struct packed {
        target_e             tgt;
        logic [PAGE_W-1:0]   ram_page;
        logic [ROMPG_W-1:0]  rom_page;
        logic                vid_hi;
    } route_t;

    // Forms the table index from selector, window number and access type.
    function automatic logic [IDX_W-1:0] build_index(
        input logic [SEL_W-1:0] sel,
        input logic [WIN_W-1:0] win,
        input logic             is_wr
    );
        logic [IDX_W-1:0] ix;
        ix     = '0;
        ix[0]  = win[0];
        ix[2]  = win[2];
        ix[3]  = win[1];
        ix[4]  = win[3];
        ix[7]  = 1'b1;
        ix[1]  = ~is_wr;
        ix[6]  = is_wr;
        ix[8]  = sel[0];
        ix[9]  = sel[1];
        ix[11] = sel[4];
        ix[12] = sel[2];
        ix[13] = sel[3];
        return ix;
    endfunction

    // True when the index matches the fixed pattern that build_index produces.
    function automatic logic index_live(input logic [IDX_W-1:0] ix);
        return ix[7] & ~ix[5] & ~ix[10] & (ix[1] ^ ix[6]);
    endfunction

    // Packs the varying index bits into the storage address.
    function automatic logic [CIDX_W-1:0] compress(input logic [IDX_W-1:0] ix);
        return {ix[13], ix[12], ix[11], ix[9], ix[8], ix[6], ix[4], ix[3], ix[2], ix[0]};
    endfunction

    // Rearranges the raw table byte into its fields.
    function automatic entry_t unpack_entry(input logic [ENT_W-1:0] raw);
        entry_t e;
        e.bank  = {raw[2], raw[1], raw[4]};
        e.rom_n = raw[6];
        e.vid_n = raw[3];
        return e;
    endfunction

endpackage

// File: rtl/bank_latch.sv
module bank_latch
    import bankdec_pkg::*;
#(
    parameter int          PORT_W   = 8,
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  SEL_PORT = 8'h50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic [PORT_W-1:0] io_port,
    input  logic [DATA_W-1:0] io_data,
    output logic [SEL_W-1:0]  sel_q
);

    logic hit;
    assign hit = io_wr && (io_port == PORT_W'(SEL_PORT));

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (hit) begin
            sel_q <= io_data[SEL_W-1:0];
        end
    end

    p_sel_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(sel_q));

    p_sel_load_r1: assert property (@(posedge clk) disable iff (rst)
        hit |=> sel_q == $past(io_data[SEL_W-1:0]));

    p_sel_clear_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> sel_q == '0);

endmodule

// File: rtl/map_table.sv
module map_table
    import bankdec_pkg::*;
#(
    parameter int TIDX_W = IDX_W,
    parameter int TENT_W = ENT_W,
    parameter int TCMP_W = CIDX_W
) (
    input  logic              clk,
    input  logic              cfg_we,
    input  logic [TIDX_W-1:0] cfg_index,
    input  logic [TENT_W-1:0] cfg_data,
    input  logic [TIDX_W-1:0] rd_index,
    output logic [TENT_W-1:0] rd_entry
);

    localparam int DEPTH = 1 << TCMP_W;

    logic [TENT_W-1:0] store [DEPTH];
    logic              wr_ok;
    logic [TCMP_W-1:0] wr_addr;
    logic [TCMP_W-1:0] rd_addr;

    assign wr_ok   = cfg_we && index_live(cfg_index);
    assign wr_addr = compress(cfg_index);
    assign rd_addr = compress(rd_index);

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            store[wr_addr] <= cfg_data;
        end
    end

    assign rd_entry = store[rd_addr];

    p_lookup_live_r4: assert property (@(posedge clk)
        index_live(rd_index));

    p_load_lands_r12: assert property (@(posedge clk)
        wr_ok && (rd_index == cfg_index) |=> rd_entry == $past(cfg_data) || rd_index != $past(rd_index));

endmodule

// File: rtl/map_resolve.sv
module map_resolve
    import bankdec_pkg::*;
#(
    parameter int RADDR_W = ADDR_W,
    parameter int RENT_W  = ENT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SEL_W-1:0]   sel,
    input  logic [RADDR_W-1:0] addr,
    input  logic               is_wr,
    input  logic [RENT_W-1:0]  raw,
    output route_t             route
);

    localparam int WIN_LSB  = RADDR_W - WIN_W;
    localparam int HALF_BIT = WIN_LSB - 1;

    entry_t             ent;
    logic [BANK_W-1:0]  bank_eff;
    logic [WIN_W-1:0]   win;

    assign win = addr[RADDR_W-1:WIN_LSB];
    assign ent = unpack_entry(raw);

    // The top bank bit is only honoured while selector bit 5 is set.
    generate
        if (BANK_W > 2) begin : g_gate
            assign bank_eff = {ent.bank[BANK_W-1] & sel[SEL_W-1], ent.bank[BANK_W-2:0]};
        end else begin : g_nogate
            assign bank_eff = ent.bank;
        end
    endgenerate

    always_comb begin
        route = '0;
        if (!ent.vid_n) begin
            route.tgt    = TGT_VIDEO;
            route.vid_hi = addr[HALF_BIT];
        end else if (!ent.rom_n) begin
            if (is_wr) begin
                route.tgt = TGT_DROP;
            end else begin
                route.tgt      = TGT_ROM;
                route.rom_page = win[ROMPG_W-1:0];
            end
        end else begin
            route.tgt      = TGT_RAM;
            route.ram_page = {bank_eff, win[2:0]};
        end
    end

    p_drop_is_write_r9: assert property (@(posedge clk) disable iff (rst)
        route.tgt == TGT_DROP |-> is_wr);

    p_rom_page_r8: assert property (@(posedge clk) disable iff (rst)
        route.tgt == TGT_ROM |-> !is_wr && route.rom_page == addr[WIN_LSB+1:WIN_LSB]);

    p_ram_low_r10: assert property (@(posedge clk) disable iff (rst)
        route.tgt == TGT_RAM |-> route.ram_page[2:0] == addr[WIN_LSB+2:WIN_LSB]);

    p_bank_gate_r6: assert property (@(posedge clk) disable iff (rst)
        !sel[SEL_W-1] |-> !route.ram_page[PAGE_W-1]);

endmodule

// File: rtl/membank_decoder.sv
module membank_decoder
    import bankdec_pkg::*;
#(
    parameter logic [7:0]  SEL_PORT = 8'h50,
    parameter logic [15:0] BOOT_PC  = 16'h8000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                io_wr,
    input  logic [7:0]          io_port,
    input  logic [7:0]          io_data,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic                cpu_wr,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_index,
    input  logic [ENT_W-1:0]    cfg_data,
    output logic                vid_sel,
    output logic                vid_upper,
    output logic                ram_sel,
    output logic [PAGE_W-1:0]   ram_page,
    output logic                rom_sel,
    output logic [ROMPG_W-1:0]  rom_page,
    output logic                wr_discard,
    output logic [ADDR_W-1:0]   boot_addr
);

    logic [SEL_W-1:0] sel_q;
    logic [IDX_W-1:0] lk_index;
    logic [ENT_W-1:0] lk_entry;
    route_t           route;

    bank_latch #(
        .PORT_W   (8),
        .DATA_W   (8),
        .SEL_PORT (SEL_PORT)
    ) u_latch (
        .clk     (clk),
        .rst     (rst),
        .io_wr   (io_wr),
        .io_port (io_port),
        .io_data (io_data),
        .sel_q   (sel_q)
    );

    assign lk_index = build_index(sel_q, cpu_addr[ADDR_W-1:ADDR_W-WIN_W], cpu_wr);

    map_table u_table (
        .clk       (clk),
        .cfg_we    (cfg_we),
        .cfg_index (cfg_index),
        .cfg_data  (cfg_data),
        .rd_index  (lk_index),
        .rd_entry  (lk_entry)
    );

    map_resolve u_resolve (
        .clk   (clk),
        .rst   (rst),
        .sel   (sel_q),
        .addr  (cpu_addr),
        .is_wr (cpu_wr),
        .raw   (lk_entry),
        .route (route)
    );

    assign vid_sel    = (route.tgt == TGT_VIDEO);
    assign vid_upper  = route.vid_hi;
    assign ram_sel    = (route.tgt == TGT_RAM);
    assign ram_page   = route.ram_page;
    assign rom_sel    = (route.tgt == TGT_ROM);
    assign rom_page   = route.rom_page;
    assign wr_discard = (route.tgt == TGT_DROP);
    assign boot_addr  = BOOT_PC;

    p_one_target_r10: assert property (@(posedge clk) disable iff (rst)
        $countones({vid_sel, ram_sel, rom_sel, wr_discard}) == 1);

    p_half_video_r7: assert property (@(posedge clk) disable iff (rst)
        vid_upper |-> vid_sel && cpu_addr[ADDR_W-WIN_W-1]);

endmodule

// File: tb/membank_decoder_bench.sv
module membank_decoder_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_wr = 1'b0;
    logic [7:0]  io_port = '0;
    logic [7:0]  io_data = '0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic        cfg_we = 1'b0;
    logic [13:0] cfg_index = '0;
    logic [7:0]  cfg_data = '0;
    logic        vid_sel, vid_upper, ram_sel, rom_sel, wr_discard;
    logic [5:0]  ram_page;
    logic [1:0]  rom_page;
    logic [15:0] boot_addr;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    membank_decoder u_membank_decoder (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_port(io_port), .io_data(io_data),
        .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cfg_we(cfg_we), .cfg_index(cfg_index),
        .cfg_data(cfg_data), .vid_sel(vid_sel), .vid_upper(vid_upper), .ram_sel(ram_sel),
        .ram_page(ram_page), .rom_sel(rom_sel), .rom_page(rom_page),
        .wr_discard(wr_discard), .boot_addr(boot_addr)
    );

    // Index per R2, R3, R4.
    function automatic logic [13:0] idx_of(logic [5:0] s, logic [3:0] w, logic wr);
        logic [13:0] x = '0;
        x[8] = s[0]; x[9] = s[1]; x[11] = s[4]; x[12] = s[2]; x[13] = s[3];
        x[0] = w[0]; x[3] = w[1]; x[2] = w[2]; x[4] = w[3];
        x[7] = 1'b1;
        if (wr) x[6] = 1'b1; else x[1] = 1'b1;
        return x;
    endfunction

    function automatic logic [7:0] fill(logic [13:0] i);
        int v;
        v = (int'(i) * 29) ^ (int'(i) >> 6) ^ 'h5A;
        return v[7:0];
    endfunction

    logic [7:0] shadow [logic [13:0]];

    // Expected packed result {vid, upper, ram, page6, rom, rpage2, drop} per R5..R10.
    function automatic logic [12:0] expect_of(logic [5:0] s, logic [3:0] w, logic wr, logic a11,
                                              logic [7:0] t, output string tag);
        logic [2:0] bank;
        bank = {t[2] & s[5], t[1], t[4]};
        if (!t[3]) begin
            tag = "R7";
            return {1'b1, a11, 1'b0, 6'd0, 1'b0, 2'd0, 1'b0};
        end else if (!t[6] && !wr) begin
            tag = "R8";
            return {1'b0, 1'b0, 1'b0, 6'd0, 1'b1, w[1:0], 1'b0};
        end else if (!t[6]) begin
            tag = "R9";
            return {1'b0, 1'b0, 1'b0, 6'd0, 1'b0, 2'd0, 1'b1};
        end
        tag = s[5] ? "R10" : "R6";
        return {1'b0, 1'b0, 1'b1, bank, w[2:0], 1'b0, 2'd0, 1'b0};
    endfunction

    task automatic check_vec(string tag, logic [12:0] act, logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b (addr %h wr %0d)", tag, act, exp, cpu_addr, cpu_wr);
        end
    endtask

    // Sweeps every window, access type and video half for selector s (R2..R10).
    task automatic sweep(logic [5:0] s, string why);
        for (int w = 0; w < 16; w++) begin
            for (int wr = 0; wr < 2; wr++) begin
                for (int h = 0; h < 2; h++) begin
                    string tag;
                    logic [12:0] exp;
                    logic [13:0] ix;
                    cpu_addr = {w[3:0], h[0], 11'h2B5};
                    cpu_wr   = wr[0];
                    ix  = idx_of(s, w[3:0], wr[0]);
                    exp = expect_of(s, w[3:0], wr[0], h[0], shadow[ix], tag);
                    #1;
                    check_vec({why, "/", tag},
                        {vid_sel, vid_upper, ram_sel, ram_page, rom_sel, rom_page, wr_discard}, exp);
                end
            end
        end
    endtask

    task automatic cfg_write(logic [13:0] ix, logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_index = ix; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic port_write(logic [7:0] p, logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_port = p; io_data = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // Table load while reset holds the selector at 0 (R12).
        for (int s = 0; s < 64; s++) begin
            if (s[5]) continue;
            for (int w = 0; w < 16; w++) begin
                for (int wr = 0; wr < 2; wr++) begin
                    logic [13:0] ix;
                    ix = idx_of(s[5:0], w[3:0], wr[0]);
                    shadow[ix] = fill(ix);
                    cfg_write(ix, shadow[ix]);
                end
            end
        end
        @(negedge clk);
        // R11: reset state and start address.
        checks++;
        if (boot_addr !== 16'h8000) begin
            errors++;
            $display("FAIL R11: boot_addr got %h expected 8000", boot_addr);
        end
        sweep(6'd0, "R11");
        rst = 1'b0;
        @(negedge clk);

        // R1: every selector value, upper data bits set to junk.
        for (int s = 0; s < 64; s++) begin
            port_write(8'h50, {s[1:0] ^ 2'b10, s[5:0]});
            sweep(s[5:0], "R1");
        end
        // R1: other port ignored; selector stays at 63.
        port_write(8'h51, 8'h00);
        port_write(8'hD0, 8'h12);
        sweep(6'd63, "R1");

        // R11: reset returns the selector to 0.
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        sweep(6'd0, "R11");

        // R12: writes to unreachable aliases change nothing.
        begin
            logic [13:0] ix;
            ix = idx_of(6'd0, 4'd5, 1'b0);
            cfg_write(ix | 14'h0020, ~shadow[ix]);
            cfg_write(ix | 14'h0400, ~shadow[ix]);
            cfg_write(ix & ~14'h0080, ~shadow[ix]);
            cfg_write(ix | 14'h0040, ~shadow[ix]);
            sweep(6'd0, "R12");
            // R12: reachable rewrite takes effect (ROM read on window 5).
            shadow[ix] = 8'h28;
            cfg_write(ix, 8'h28);
            sweep(6'd0, "R12");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule